// File: doc/BRIEF.md
# Audio capture sample packer

This block sits between a group of audio capture sources and a memory-write path. One source is chosen by a 3-bit select. For every valid 32-bit sample slot from that source, the block takes the bit field between a programmable top position and a programmable bottom position. It shifts that field down to bit 0 and fills the bits above it with either zeros or copies of the field's top bit. The result is then placed in a container that is 8, 16 or 32 bits wide. Containers are gathered into 64-bit words, and each completed word is presented with a one-cycle valid strobe and the byte address it is meant for.

The write address starts at a programmed initial value and moves up by eight bytes for each word. Software drives the restart input low, then high, then low. The low-to-high step sends the address back to the initial value and throws away any word that is only partly filled. A fill counter raises a flush request on every word that brings the count of words up to the programmed threshold plus one. The block never holds up its sources. Any sample that arrives while the configuration is unusable is dropped.

Top module: `capPacker`

## Requirements
- R1: Type code 0 packs eight 8-bit containers per word. The first accepted sample goes in bits 7:0, the next in bits 15:8, and so on up to bits 63:56. The word is emitted with wordValid one cycle after the clock edge that accepts its eighth sample.
- R2: Type code 2 packs four 16-bit containers per word. Lane n occupies bits 16n+15:16n, and lane 0 is filled first.
- R3: Type code 4 packs two 32-bit containers per word. The first sample goes in bits 31:0 and the second in bits 63:32.
- R4: Each container holds sample bits cfgMsb down to cfgLsb, moved down to bit 0. The field width is W = cfgMsb − cfgLsb + 1, and cfgMsb ≥ cfgLsb is assumed. If W is larger than the container, only the low container bits are kept.
- R5: When cfgSignExt is 1, the container bits above the field are copies of sample bit cfgMsb. When it is 0, they are zero.
- R6: Only srcData slot cfgSrcSel (bits 32·s+31:32·s) and srcValidVec bit cfgSrcSel are used. Samples on other slots are ignored, and so is a selected slot whose valid bit is low.
- R7: Select values 5 and 7, and type codes other than 0, 2 and 4, cause every sample to be dropped. No word is emitted, no lane is consumed, and the block never stalls. Packing continues from the same lane once the configuration is valid again.
- R8: The first word after reset or after a restart carries wordAddr = initAddr. Each following word carries the previous address plus 8.
- R9: A rising edge of forceFinish, seen at a clock edge, has three effects: it discards the partial word, reloads the address from initAddr, and clears the fill counter. Any sample in that same cycle is dropped. Holding forceFinish high, or taking it low, has no further effect.
- R10: flushReq is high, together with wordValid, on every word that brings the count of words since reset or restart to cfgThreshold+1 words. The count then starts again.
- R11: In reset (synchronous, rstN low), and in the cycle after it, wordValid and flushReq are 0 and wordData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| srcData | input | NUM_SRC*32 | One 32-bit sample slot per capture source |
| srcValidVec | input | NUM_SRC | Per-source sample valid |
| cfgSrcSel | input | 3 | Source select (5 and 7 unused) |
| cfgType | input | 3 | Packing type code (0, 2, 4) |
| cfgMsb | input | 5 | Top bit position of the field |
| cfgLsb | input | 5 | Bottom bit position of the field |
| cfgSignExt | input | 1 | Fill above the field with its top bit |
| cfgThreshold | input | THR_W | Words per flush request, minus one |
| initAddr | input | ADDR_W | Initial write byte address |
| forceFinish | input | 1 | Restart control, acts on its rising edge |
| wordValid | output | 1 | Packed word strobe |
| wordData | output | 64 | Packed word |
| wordAddr | output | ADDR_W | Byte address of the packed word |
| flushReq | output | 1 | Fill threshold reached |

## Verification
The assertions rely on a few conditions about the inputs. The configuration changes only just before a restart, so it is steady while a word is being packed. initAddr is steady between restarts. The field bounds satisfy cfgMsb ≥ cfgLsb. The stimulus keeps to these conditions: each new configuration is applied at a falling edge and is always followed by a low-high-low restart. Only legal field pairs come from the sweep tables. The one exception is the invalid-select and invalid-type runs, which change the configuration without a restart on purpose. This shows that the lane position carries over unchanged.

// File: rtl/capPkg.sv
package capPkg;
  localparam int SAMPLE_W  = 32;
  localparam int POS_W     = $clog2(SAMPLE_W);
  localparam int WORD_W    = 64;
  localparam int BYTES     = WORD_W / 8;
  localparam int LANE_W    = $clog2(BYTES);
  localparam int LANE_CNTW = LANE_W + 1;

  typedef enum logic [2:0] {
    PACK_B8  = 3'd0,
    PACK_B16 = 3'd2,
    PACK_B32 = 3'd4
  } packType_e;

  typedef struct packed {
    logic              accept;
    logic [LANE_W-1:0] lane;
    logic              last;
  } packStrobe_t;

  function automatic logic typeUsable(input logic [2:0] t);
    return (t == PACK_B8) || (t == PACK_B16) || (t == PACK_B32);
  endfunction

  function automatic logic selUsable(input logic [2:0] s);
    return (s != 3'd5) && (s != 3'd7);
  endfunction

  function automatic logic [LANE_CNTW-1:0] lanesOf(input logic [2:0] t);
    case (t)
      PACK_B8:  return LANE_CNTW'(BYTES);
      PACK_B16: return LANE_CNTW'(BYTES / 2);
      PACK_B32: return LANE_CNTW'(BYTES / 4);
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/capCtrl.sv
module capCtrl
  import capPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 32,
  parameter int THR_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcValidVec,
  input  logic [2:0]         cfgSrcSel,
  input  logic [2:0]         cfgType,
  input  logic [THR_W-1:0]   cfgThreshold,
  input  logic [ADDR_W-1:0]  initAddr,
  input  logic               forceFinish,
  output packStrobe_t        strobe,
  output logic               wordValid,
  output logic [ADDR_W-1:0]  wordAddr,
  output logic               flushReq
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_W / 8);

  logic                 ffPrev;
  logic                 ffRise;
  logic                 selValid;
  logic [LANE_W-1:0]    laneCnt;
  logic [LANE_CNTW-1:0] laneTotal;
  logic [ADDR_W-1:0]    curAddr;
  logic [THR_W-1:0]     fillCnt;

  assign ffRise    = forceFinish && !ffPrev;
  assign laneTotal = lanesOf(cfgType);

  always_comb begin
    selValid = 1'b0;
    if (selUsable(cfgSrcSel) && (int'(cfgSrcSel) < NUM_SRC))
      selValid = srcValidVec[cfgSrcSel];
  end

  always_comb begin
    strobe.accept = !ffRise && selValid && typeUsable(cfgType);
    strobe.lane   = laneCnt;
    strobe.last   = strobe.accept &&
                    ({1'b0, laneCnt} == laneTotal - LANE_CNTW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ffPrev    <= 1'b0;
      laneCnt   <= '0;
      curAddr   <= initAddr;
      fillCnt   <= '0;
      wordValid <= 1'b0;
      wordAddr  <= '0;
      flushReq  <= 1'b0;
    end else begin
      ffPrev    <= forceFinish;
      wordValid <= 1'b0;
      flushReq  <= 1'b0;
      if (ffRise) begin
        laneCnt <= '0;
        curAddr <= initAddr;
        fillCnt <= '0;
      end else if (strobe.accept) begin
        if (strobe.last) begin
          laneCnt   <= '0;
          wordValid <= 1'b1;
          wordAddr  <= curAddr;
          curAddr   <= curAddr + ADDR_STEP;
          if (fillCnt == cfgThreshold) begin
            flushReq <= 1'b1;
            fillCnt  <= '0;
          end else begin
            fillCnt <= fillCnt + THR_W'(1);
          end
        end else begin
          laneCnt <= laneCnt + LANE_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/capDatapath.sv
module capDatapath
  import capPkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  packStrobe_t                 strobe,
  input  logic [NUM_SRC*SAMPLE_W-1:0] srcData,
  input  logic [2:0]                  cfgSrcSel,
  input  logic [2:0]                  cfgType,
  input  logic [POS_W-1:0]            cfgMsb,
  input  logic [POS_W-1:0]            cfgLsb,
  input  logic                        cfgSignExt,
  output logic [WORD_W-1:0]           wordData
);
  logic [2:0]          selIdx;
  logic [SAMPLE_W-1:0] sample;
  logic [SAMPLE_W-1:0] shifted;
  logic [SAMPLE_W-1:0] fieldMask;
  logic [SAMPLE_W-1:0] extended;
  logic [WORD_W-1:0]   replicated;
  logic [WORD_W-1:0]   bufWord;
  logic [WORD_W-1:0]   merged;

  assign selIdx = (int'(cfgSrcSel) < NUM_SRC) ? cfgSrcSel : 3'd0;
  assign sample = srcData[int'(selIdx)*SAMPLE_W +: SAMPLE_W];

  always_comb begin
    shifted   = sample >> cfgLsb;
    fieldMask = {SAMPLE_W{1'b1}} >> (POS_W'(SAMPLE_W - 1) - (cfgMsb - cfgLsb));
    if (cfgSignExt && sample[cfgMsb])
      extended = shifted | ~fieldMask;
    else
      extended = shifted & fieldMask;
  end

  always_comb begin
    case (cfgType)
      PACK_B8:  replicated = {(WORD_W/8){extended[7:0]}};
      PACK_B16: replicated = {(WORD_W/16){extended[15:0]}};
      default:  replicated = {(WORD_W/SAMPLE_W){extended}};
    endcase
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic byteEn;
    always_comb begin
      case (cfgType)
        PACK_B8:  byteEn = (LANE_W'(b) == strobe.lane);
        PACK_B16: byteEn = (LANE_W'(b / 2) == strobe.lane);
        default:  byteEn = (LANE_W'(b / 4) == strobe.lane);
      endcase
    end
    assign merged[8*b +: 8] = (strobe.accept && byteEn) ?
                              replicated[8*b +: 8] : bufWord[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufWord  <= '0;
      wordData <= '0;
    end else begin
      if (strobe.accept) bufWord <= merged;
      if (strobe.last)   wordData <= merged;
    end
  end
endmodule

// File: rtl/capPacker.sv
module capPacker
  import capPkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 32,
  parameter int THR_W   = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SRC*SAMPLE_W-1:0] srcData,
  input  logic [NUM_SRC-1:0]          srcValidVec,
  input  logic [2:0]                  cfgSrcSel,
  input  logic [2:0]                  cfgType,
  input  logic [POS_W-1:0]            cfgMsb,
  input  logic [POS_W-1:0]            cfgLsb,
  input  logic                        cfgSignExt,
  input  logic [THR_W-1:0]            cfgThreshold,
  input  logic [ADDR_W-1:0]           initAddr,
  input  logic                        forceFinish,
  output logic                        wordValid,
  output logic [WORD_W-1:0]           wordData,
  output logic [ADDR_W-1:0]           wordAddr,
  output logic                        flushReq
);
  packStrobe_t strobe;

  capCtrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .THR_W(THR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcValidVec(srcValidVec), .cfgSrcSel(cfgSrcSel),
    .cfgType(cfgType), .cfgThreshold(cfgThreshold), .initAddr(initAddr),
    .forceFinish(forceFinish), .strobe(strobe), .wordValid(wordValid),
    .wordAddr(wordAddr), .flushReq(flushReq)
  );

  capDatapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcData(srcData),
    .cfgSrcSel(cfgSrcSel), .cfgType(cfgType), .cfgMsb(cfgMsb),
    .cfgLsb(cfgLsb), .cfgSignExt(cfgSignExt), .wordData(wordData)
  );
endmodule

// File: rtl/capPackerChk.sv
module capPackerChk #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcValidVec,
  input logic [2:0]         cfgSrcSel,
  input logic [2:0]         cfgType,
  input logic [ADDR_W-1:0]  initAddr,
  input logic               forceFinish,
  input logic               wordValid,
  input logic [ADDR_W-1:0]  wordAddr,
  input logic               flushReq
);
  logic              ffSeen;
  logic [ADDR_W-1:0] expAddr;
  logic              cfgOk;
  logic              selLow;

  assign cfgOk = (cfgSrcSel != 3'd5) && (cfgSrcSel != 3'd7) &&
                 ((cfgType == 3'd0) || (cfgType == 3'd2) || (cfgType == 3'd4));
  assign selLow = (int'(cfgSrcSel) < NUM_SRC) ? !srcValidVec[cfgSrcSel] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ffSeen  <= 1'b0;
      expAddr <= initAddr;
    end else begin
      ffSeen <= forceFinish;
      if (forceFinish && !ffSeen) expAddr <= initAddr;
      else if (wordValid)         expAddr <= wordAddr + ADDR_W'(8);
    end
  end

  // R8
  addr_sequence_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> wordAddr == expAddr);

  // R10
  flush_with_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> wordValid);

  // R7
  bad_cfg_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOk |=> !wordValid);

  // R9
  finish_no_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (forceFinish && !ffSeen) |=> !wordValid);

  // R6
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    selLow |=> !wordValid);
endmodule

bind capPacker capPackerChk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_capPackerChk (
  .clk(clk), .rstN(rstN), .srcValidVec(srcValidVec), .cfgSrcSel(cfgSrcSel),
  .cfgType(cfgType), .initAddr(initAddr), .forceFinish(forceFinish),
  .wordValid(wordValid), .wordAddr(wordAddr), .flushReq(flushReq)
);

// File: tb/test_capPacker.sv
`timescale 1ns/1ps
module test_capPacker;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NS*32-1:0] srcData;
  logic [NS-1:0] srcValidVec;
  logic [2:0]    cfgSrcSel, cfgType;
  logic [4:0]    cfgMsb, cfgLsb;
  logic          cfgSignExt;
  logic [7:0]    cfgThreshold;
  logic [31:0]   initAddr;
  logic          forceFinish;
  logic          wordValid;
  logic [63:0]   wordData;
  logic [31:0]   wordAddr;
  logic          flushReq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  int          mLane;
  logic [63:0] mAcc;
  logic [31:0] mAddr;
  int          mFill;
  logic        mFfPrev;

  always #2.5 clk = ~clk;

  capPacker i_capPacker (
    .clk(clk), .rstN(rstN), .srcData(srcData), .srcValidVec(srcValidVec),
    .cfgSrcSel(cfgSrcSel), .cfgType(cfgType), .cfgMsb(cfgMsb), .cfgLsb(cfgLsb),
    .cfgSignExt(cfgSignExt), .cfgThreshold(cfgThreshold), .initAddr(initAddr),
    .forceFinish(forceFinish), .wordValid(wordValid), .wordData(wordData),
    .wordAddr(wordAddr), .flushReq(flushReq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int lanesFor(input logic [2:0] t);
    return (t == 3'd0) ? 8 : (t == 3'd2) ? 4 : (t == 3'd4) ? 2 : 0;
  endfunction

  // R4 / R5: field extraction and fill computed arithmetically
  function automatic logic [63:0] fieldOf(input logic [31:0] s);
    int w;
    logic [63:0] m, f;
    w = int'(cfgMsb) - int'(cfgLsb) + 1;
    m = (64'd1 << w) - 64'd1;
    f = (64'(s) >> cfgLsb) & m;
    if (cfgSignExt && s[cfgMsb]) f = f | ~m;
    return f;
  endfunction

  function automatic logic [31:0] patt(input int k);
    return (32'h9E3779B9 * 32'(k + 1)) ^ 32'(k << 7);
  endfunction

  // one cycle of stimulus; v drives selected source's valid, ff drives forceFinish
  task automatic cycle(input logic [31:0] s, input bit v, input bit ff);
    bit rise, ok, emit, expFlush;
    int lanes;
    logic [63:0] f;
    @(negedge clk);
    for (int i = 0; i < NS; i++) srcData[i*32 +: 32] = ~s ^ 32'(i * 32'h01010101);
    srcData[int'(cfgSrcSel)*32 +: 32] = s;
    srcValidVec = v ? 8'hFF : ~(8'd1 << cfgSrcSel);
    forceFinish = ff;
    rise = ff && !mFfPrev;
    mFfPrev = ff;
    lanes = lanesFor(cfgType);
    ok = v && (cfgSrcSel != 3'd5) && (cfgSrcSel != 3'd7) && (lanes != 0);
    emit = 0; expFlush = 0;
    if (rise) begin
      mLane = 0; mAddr = initAddr; mFill = 0;
    end else if (ok) begin
      f = fieldOf(s);
      case (cfgType)
        3'd0: mAcc[mLane*8 +: 8] = f[7:0];
        3'd2: mAcc[mLane*16 +: 16] = f[15:0];
        default: mAcc[mLane*32 +: 32] = f[31:0];
      endcase
      mLane++;
      if (mLane == lanes) begin
        emit = 1; mLane = 0;
        if (mFill == int'(cfgThreshold)) begin expFlush = 1; mFill = 0; end
        else mFill++;
      end
    end
    @(posedge clk); #1;
    if (emit) begin
      chk(wordValid == 1'b1, "R1/R2/R3 word strobe", 64'(wordValid), 64'd1);
      chk(wordData == mAcc, (cfgType == 0) ? "R1 R4 R5 data" :
          (cfgType == 2) ? "R2 R4 R5 data" : "R3 R4 R5 data", wordData, mAcc);
      chk(wordAddr == mAddr, "R8 address", 64'(wordAddr), 64'(mAddr));
      chk(flushReq == expFlush, "R10 flush", 64'(flushReq), 64'(expFlush));
      mAddr = mAddr + 32'd8;
    end else begin
      chk(wordValid == 1'b0, rise ? "R9 no word on restart" :
          v ? "R7 no word" : "R6 no word", 64'(wordValid), 64'd0);
      chk(flushReq == 1'b0, "R10 flush idle", 64'(flushReq), 64'd0);
    end
  endtask

  task automatic restart();
    cycle(32'h0, 0, 0);
    cycle(32'h0, 0, 1);
    cycle(32'h0, 0, 0);
  endtask

  task automatic setCfg(input logic [2:0] sel, input logic [2:0] t,
                        input logic [4:0] msb, input logic [4:0] lsb,
                        input bit sgn, input logic [7:0] thr);
    @(negedge clk);
    cfgSrcSel = sel; cfgType = t; cfgMsb = msb; cfgLsb = lsb;
    cfgSignExt = sgn; cfgThreshold = thr;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int msbs[6] = '{31, 31, 31, 20, 3, 31};
    int lsbs[6] = '{24, 16, 0, 9, 0, 31};
    int srcs[6] = '{0, 1, 2, 3, 4, 6};
    int types[3] = '{0, 2, 4};
    int k = 0;
    rstN = 0; srcData = '0; srcValidVec = '0; forceFinish = 0;
    cfgSrcSel = 0; cfgType = 0; cfgMsb = 31; cfgLsb = 24; cfgSignExt = 0;
    cfgThreshold = 2; initAddr = 32'h1000_0000;
    mLane = 0; mAcc = '0; mAddr = initAddr; mFill = 0; mFfPrev = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(wordValid == 0 && flushReq == 0 && wordData == 0, "R11 in reset",
        {wordData[61:0], wordValid, flushReq}, 64'd0);
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;
    chk(wordValid == 0 && flushReq == 0 && wordData == 0, "R11 after reset",
        {wordData[61:0], wordValid, flushReq}, 64'd0);

    // R8: first word after reset uses initAddr without any restart
    for (int i = 0; i < 8; i++) cycle(patt(k++), 1, 0);

    // R1 R2 R3 R4 R5 R6 R10 sweep
    foreach (types[ti])
      for (int sg = 0; sg < 2; sg++)
        foreach (msbs[fi]) begin
          setCfg(3'(srcs[(fi + ti) % 6]), 3'(types[ti]), 5'(msbs[fi]),
                 5'(lsbs[fi]), sg[0], 8'((fi + sg) % 4));
          restart();
          for (int i = 0; i < 24; i++) cycle(patt(k++), (i % 7) != 5, 0);
        end

    // R7: unused select drops samples, lane position carries over
    setCfg(3'd0, 3'd2, 5'd31, 5'd16, 1'b1, 8'd1);
    restart();
    cycle(patt(k++), 1, 0);
    cfgSrcSel = 3'd5;
    for (int i = 0; i < 10; i++) cycle(patt(k++), 1, 0);
    cfgSrcSel = 3'd7;
    for (int i = 0; i < 4; i++) cycle(patt(k++), 1, 0);
    cfgSrcSel = 3'd6;
    for (int i = 0; i < 3; i++) cycle(patt(k++), 1, 0);
    // R7: unsupported type codes
    for (int t = 1; t < 8; t++)
      if (t != 2 && t != 4) begin
        cfgType = 3'(t);
        for (int i = 0; i < 5; i++) cycle(patt(k++), 1, 0);
      end
    cfgType = 3'd2;
    for (int i = 0; i < 8; i++) cycle(patt(k++), 1, 0);

    // R9: restart mid-word discards partial word, new initAddr, ff held high
    setCfg(3'd3, 3'd0, 5'd15, 5'd8, 1'b0, 8'd0);
    restart();
    for (int i = 0; i < 5; i++) cycle(patt(k++), 1, 0);
    initAddr = 32'h0000_2000;
    cycle(patt(k++), 1, 1);
    for (int i = 0; i < 16; i++) cycle(patt(k++), 1, 1);
    for (int i = 0; i < 8; i++) cycle(patt(k++), 1, 0);

    // R5: extreme values with sign fill into narrow containers
    setCfg(3'd4, 3'd0, 5'd31, 5'd28, 1'b1, 8'd3);
    restart();
    for (int i = 0; i < 16; i++)
      cycle((i % 2) ? 32'h8000_0000 : 32'h7FFF_FFFF, 1, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule